// File: doc/BRIEF.md
# PHY Test-Port Parameter Sequencer

This block is a small hardware sequencer that tunes a serial-link PHY after power-up. The only access it has to the PHY's internal tuning registers is a narrow indirect port. It drives a 32-bit command word toward the PHY and samples a 32-bit response word. For each entry of a fixed, built-in list of three tuning parameters, it performs a read-modify-write of one 8-bit PHY register. Once the list is done, it waits a programmable number of cycles and then takes the PHY out of reset through a 9-bit reset-control output that is held in manual mode.

One pulse on the start input launches the whole sequence. While the sequence runs, the busy output stays high, and a single-cycle done pulse marks its end. When the legacy input is high at start, the PHY has no tuning registers and no reset control of its own. In that case the sequencer touches nothing and reports done at once.

Every action on the port follows the same rule: the command word is held for a fixed number of settle cycles before anything else happens. Each update therefore takes five port actions: a read, a write bracketed by a one-action write strobe, and a trailing dummy read.

Top module: `phy_tparam_seq`

## Requirements
- R1: The command word is laid out as follows. Bit 0 is the write strobe, bits 5:1 hold the register address and bits 13:6 hold the data byte. Every other bit of the word is driven to zero.
- R2: Each command word stays on the port for exactly SETTLE_READS cycles (default 2) before the next word replaces it.
- R3: A read of register N presents address N with data byte 1 and the strobe at 0. The read data is taken from bits 7:0 of the response word at the end of the last settle cycle.
- R4: A write presents the new data byte and the address three times in a row: first with the strobe at 0, then at 1, then at 0 again. The strobe is never high outside such a bracket, and never high while the block is idle.
- R5: After each write, the block issues a read of the same address and discards its result.
- R6: Updates run in a fixed order. Register 0 gets bit 3 forced to 1. Register 6 gets bits 5:0 forced to 0. Register 26 gets bits 7:4 set to 5. A full run therefore presents 15 command words and writes no other register.
- R7: The written byte equals (read byte AND NOT mask) OR (value AND mask), so bits outside each field keep the value read from the PHY.
- R8: The reset-control output has bit 8 as the manual-mode bit and bit 0 as the active-low release bit. It is 0x100 after reset and again in the cycle after a non-legacy start. It becomes 0x101 exactly SETTLE_READS + PRE_DLY cycles after the last command word appears.
- R9: done is a pulse one cycle wide. It rises POST_DLY cycles (default 16) after the reset release.
- R10: busy is 0 after reset. It is high from the cycle after an accepted non-legacy start until done, and it is never high together with done.
- R11: A start pulse that arrives while busy is high is ignored. The run keeps its word sequence and its timing, and no second done follows.
- R12: With legacy high at start, done pulses in the next cycle. busy stays low, no command word changes and the reset-control output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a sequence when the block is idle |
| legacy_i | input | 1 | Sampled with start; selects the no-tuning variant |
| tst_out_i | input | WORD_W | Response word from the PHY test port |
| tst_in_o | output | WORD_W | Command word to the PHY test port |
| rst_ctl_o | output | RST_W | PHY reset control: manual-mode bit and release bit |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Several properties are checked on every clock cycle:
- busy and done are never high together, and done lasts one cycle.
- Every rising write strobe follows the same word with the strobe low, and the strobe is never high while idle.
- A changed command word stays put for at least another cycle.
- The release bit never appears without the manual-mode bit.
- A legacy start produces done without disturbing the port.

Other behaviour shows only in the bench's scenarios, where a behavioural register file stands in for the PHY:
- the exact list and order of the 15 words;
- the merged bytes that end up in the PHY registers, with random, all-zero and all-one starting contents;
- the exact delays before release and before done;
- the run staying unchanged when a second start arrives mid-sequence.

// File: rtl/phy_tparam_pkg.sv
package phy_tparam_pkg;

   localparam int TP_ADDR_W     = 5;
   localparam int TP_DATA_W     = 8;
   localparam int TP_NUM_PARAMS = 3;

   typedef struct packed {
      logic [TP_ADDR_W-1:0] addr;
      logic [TP_DATA_W-1:0] mask;
      logic [TP_DATA_W-1:0] value;
   } tp_entry_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_PORT,
      SQ_PRE,
      SQ_POST
   } sq_state_t;

   // phase names the word currently held on the port
   typedef enum logic [2:0] {
      PH_RD_CMD,
      PH_WR_SETUP,
      PH_WR_STROBE,
      PH_WR_HOLD,
      PH_RD_DUMMY
   } ph_t;

   // tuning list, applied in index order
   function automatic tp_entry_t tp_entry(input int unsigned idx);
      tp_entry_t e;
      case (idx)
         0:       e = '{addr: 5'd0,  mask: 8'h08, value: 8'h08};
         1:       e = '{addr: 5'd6,  mask: 8'h3F, value: 8'h00};
         2:       e = '{addr: 5'd26, mask: 8'hF0, value: 8'h50};
         default: e = '{default: '0};
      endcase
      return e;
   endfunction

   function automatic logic [TP_ADDR_W-1:0] tp_addr(input int unsigned idx);
      tp_entry_t e;
      e = tp_entry(idx);
      return e.addr;
   endfunction

endpackage

// File: rtl/phy_tparam_timer.sv
module phy_tparam_timer #(
   parameter int MAX_COUNT = 16,
   parameter int CW        = $clog2(MAX_COUNT + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          last_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign last_o = (cnt_q == CW'(1));

   AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> (load_val_i != '0)); // R2

endmodule

// File: rtl/phy_tparam_word.sv
module phy_tparam_word #(
   parameter int WORD_W   = 32,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 5,
   parameter int DATA_LSB = 6,
   parameter int ADDR_LSB = 1,
   parameter int WE_BIT   = 0
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   output logic [WORD_W-1:0] word_o
);

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == WE_BIT) begin : g_we
         assign word_o[b] = we_i;
      end else if (b >= ADDR_LSB && b < ADDR_LSB + ADDR_W) begin : g_addr
         assign word_o[b] = addr_i[b-ADDR_LSB];
      end else if (b >= DATA_LSB && b < DATA_LSB + DATA_W) begin : g_data
         assign word_o[b] = data_i[b-DATA_LSB];
      end else begin : g_zero
         assign word_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/phy_tparam_merge.sv
module phy_tparam_merge #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] mask_i,
   input  logic [DATA_W-1:0] val_i,
   output logic [DATA_W-1:0] new_o
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign new_o[b] = mask_i[b] ? val_i[b] : old_i[b];
   end

endmodule

// File: rtl/phy_tparam_seq.sv
module phy_tparam_seq
   import phy_tparam_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 5,
   parameter int DATA_LSB     = 6,
   parameter int ADDR_LSB     = 1,
   parameter int WE_BIT       = 0,
   parameter int RD_LSB       = 0,
   parameter int SETTLE_READS = 2,
   parameter int PRE_DLY      = 16,
   parameter int POST_DLY     = 16,
   parameter int RST_W        = 9,
   parameter int RST_MAN_BIT  = 8,
   parameter int RST_REL_BIT  = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              legacy_i,
   input  logic [WORD_W-1:0] tst_out_i,
   output logic [WORD_W-1:0] tst_in_o,
   output logic [RST_W-1:0]  rst_ctl_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int DLY_MAX = (PRE_DLY > POST_DLY) ? PRE_DLY : POST_DLY;
   localparam int DLY_CW  = $clog2(DLY_MAX + 1);
   localparam int SET_CW  = $clog2(SETTLE_READS + 1);
   localparam int IDX_W   = (TP_NUM_PARAMS > 1) ? $clog2(TP_NUM_PARAMS) : 1;
   localparam logic [RST_W-1:0]  RST_HOLD_V = RST_W'(1) << RST_MAN_BIT;
   localparam logic [RST_W-1:0]  RST_RUN_V  = RST_HOLD_V | (RST_W'(1) << RST_REL_BIT);
   localparam logic [WORD_W-1:0] WE_MASK    = WORD_W'(1) << WE_BIT;

   // elaboration-time parameter checks
   if (ADDR_W != TP_ADDR_W || DATA_W != TP_DATA_W) begin : g_bad_width
      $error("field widths must match the tuning list package");
   end
   if (DATA_LSB < ADDR_LSB + ADDR_W || DATA_LSB + DATA_W > WORD_W) begin : g_bad_layout
      $error("data field overlaps address field or exceeds the word");
   end
   if (WE_BIT >= ADDR_LSB && WE_BIT < DATA_LSB + DATA_W) begin : g_bad_we
      $error("strobe bit collides with address or data field");
   end
   if (RD_LSB + DATA_W > WORD_W) begin : g_bad_rd
      $error("read lane exceeds the response word");
   end
   if (SETTLE_READS < 1 || PRE_DLY < 1 || POST_DLY < 1) begin : g_bad_time
      $error("settle and delay counts must be at least one");
   end
   if (RST_MAN_BIT == RST_REL_BIT || RST_MAN_BIT >= RST_W || RST_REL_BIT >= RST_W) begin : g_bad_rst
      $error("reset control bit positions invalid");
   end

   sq_state_t          state_q;
   ph_t                phase_q;
   logic [IDX_W-1:0]   pidx_q;
   logic [DATA_W-1:0]  new_q;
   logic [WORD_W-1:0]  tst_in_q;
   logic [RST_W-1:0]   rst_ctl_q;
   logic               busy_q;
   logic               done_q;

   tp_entry_t          cur;
   logic [DATA_W-1:0]  read_byte;
   logic [DATA_W-1:0]  merged;
   logic [DATA_W-1:0]  pres_data;
   logic [ADDR_W-1:0]  pres_addr;
   logic               pres_we;
   logic [WORD_W-1:0]  pres_word;
   logic               settle_last;
   logic               dly_last;
   logic               last_param;
   logic               launch;
   logic               port_adv;
   logic               seq_end;
   logic               settle_load;
   logic               dly_load;
   logic [DLY_CW-1:0]  dly_val;
   logic               tst_out_unused;

   assign tst_out_unused = ^tst_out_i;

   assign cur        = tp_entry(32'(pidx_q));
   assign read_byte  = tst_out_i[RD_LSB +: DATA_W];
   assign last_param = (pidx_q == IDX_W'(TP_NUM_PARAMS - 1));
   assign launch     = (state_q == SQ_IDLE) && start_i && !legacy_i;
   assign port_adv   = (state_q == SQ_PORT) && settle_last;
   assign seq_end    = port_adv && (phase_q == PH_RD_DUMMY) && last_param;
   assign settle_load = launch || (port_adv && !seq_end);
   assign dly_load   = seq_end || ((state_q == SQ_PRE) && dly_last);
   assign dly_val    = seq_end ? DLY_CW'(PRE_DLY) : DLY_CW'(POST_DLY);

   phy_tparam_merge #(.DATA_W(DATA_W)) u_merge (
      .old_i  (read_byte),
      .mask_i (cur.mask),
      .val_i  (cur.value),
      .new_o  (merged)
   );

   // next word to present on the port
   always_comb begin
      pres_data = DATA_W'(1);
      pres_addr = cur.addr;
      pres_we   = 1'b0;
      if (state_q == SQ_IDLE) begin
         pres_addr = tp_addr(0);
      end else begin
         case (phase_q)
            PH_RD_CMD:    pres_data = merged;
            PH_WR_SETUP:  begin
               pres_data = new_q;
               pres_we   = 1'b1;
            end
            PH_WR_STROBE: pres_data = new_q;
            PH_WR_HOLD:   pres_data = DATA_W'(1);
            PH_RD_DUMMY:  pres_addr = tp_addr(32'(pidx_q) + 32'd1);
            default:      pres_data = DATA_W'(1);
         endcase
      end
   end

   phy_tparam_word #(
      .WORD_W   (WORD_W),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .DATA_LSB (DATA_LSB),
      .ADDR_LSB (ADDR_LSB),
      .WE_BIT   (WE_BIT)
   ) u_word (
      .data_i (pres_data),
      .addr_i (pres_addr),
      .we_i   (pres_we),
      .word_o (pres_word)
   );

   phy_tparam_timer #(.MAX_COUNT(SETTLE_READS), .CW(SET_CW)) u_settle (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (settle_load),
      .load_val_i (SET_CW'(SETTLE_READS)),
      .last_o     (settle_last)
   );

   phy_tparam_timer #(.MAX_COUNT(DLY_MAX), .CW(DLY_CW)) u_delay (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (dly_load),
      .load_val_i (dly_val),
      .last_o     (dly_last)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= SQ_IDLE;
         phase_q   <= PH_RD_CMD;
         pidx_q    <= '0;
         new_q     <= '0;
         tst_in_q  <= '0;
         rst_ctl_q <= RST_HOLD_V;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  if (legacy_i) begin
                     done_q <= 1'b1;
                  end else begin
                     busy_q    <= 1'b1;
                     rst_ctl_q <= RST_HOLD_V;
                     pidx_q    <= '0;
                     phase_q   <= PH_RD_CMD;
                     tst_in_q  <= pres_word;
                     state_q   <= SQ_PORT;
                  end
               end
            end
            SQ_PORT: begin
               if (settle_last) begin
                  case (phase_q)
                     PH_RD_CMD: begin
                        new_q    <= merged;
                        phase_q  <= PH_WR_SETUP;
                        tst_in_q <= pres_word;
                     end
                     PH_WR_SETUP: begin
                        phase_q  <= PH_WR_STROBE;
                        tst_in_q <= pres_word;
                     end
                     PH_WR_STROBE: begin
                        phase_q  <= PH_WR_HOLD;
                        tst_in_q <= pres_word;
                     end
                     PH_WR_HOLD: begin
                        phase_q  <= PH_RD_DUMMY;
                        tst_in_q <= pres_word;
                     end
                     default: begin
                        if (last_param) begin
                           state_q <= SQ_PRE;
                        end else begin
                           pidx_q   <= pidx_q + IDX_W'(1);
                           phase_q  <= PH_RD_CMD;
                           tst_in_q <= pres_word;
                        end
                     end
                  endcase
               end
            end
            SQ_PRE: begin
               if (dly_last) begin
                  rst_ctl_q <= RST_RUN_V;
                  state_q   <= SQ_POST;
               end
            end
            SQ_POST: begin
               if (dly_last) begin
                  done_q  <= 1'b1;
                  busy_q  <= 1'b0;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign tst_in_o  = tst_in_q;
   assign rst_ctl_o = rst_ctl_q;
   assign busy_o    = busy_q;
   assign done_o    = done_q;

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9

   AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(busy_o && done_o)); // R10

   AST_STROBE_BRACKET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tst_in_o[WE_BIT]) |-> ((tst_in_o & ~WE_MASK) == $past(tst_in_o))); // R4

   AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tst_in_o[WE_BIT] |-> busy_o); // R4

   if (SETTLE_READS >= 2) begin : g_hold_chk
      AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (busy_o && !$stable(tst_in_o)) |=> $stable(tst_in_o)); // R2
   end

   AST_RELEASE_MANUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ctl_o[RST_REL_BIT] |-> rst_ctl_o[RST_MAN_BIT]); // R8

   AST_LEGACY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && legacy_i && !busy_o) |=> (done_o && $stable(tst_in_o) && $stable(rst_ctl_o))); // R12

endmodule

// File: tb/phy_tparam_seq_tb_top.sv
`timescale 1ns/1ps
module phy_tparam_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic        legacy;
   logic [31:0] tst_out;
   logic [31:0] tst_in;
   logic [8:0]  rst_ctl;
   logic        busy;
   logic        done;

   always #4 clk = ~clk;

   // behavioural PHY register file
   logic [7:0]  mem      [0:31];
   logic [7:0]  init_arr [0:31];
   logic        load_req = 1'b0;
   logic [23:0] junk     = '0;

   assign tst_out = {junk, mem[tst_in[5:1]]};

   always @(posedge clk) begin
      if (load_req) begin
         for (int i = 0; i < 32; i++) mem[i] <= init_arr[i];
      end else if (tst_in[0]) begin
         mem[tst_in[5:1]] <= tst_in[13:6];
      end
   end

   phy_tparam_seq dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .legacy_i  (legacy),
      .tst_out_i (tst_out),
      .tst_in_o  (tst_in),
      .rst_ctl_o (rst_ctl),
      .busy_o    (busy),
      .done_o    (done)
   );

   int total = 0;
   int bad   = 0;

   // port monitor
   logic        mon_clr = 1'b0;
   logic [31:0] wlog [0:31];
   logic [31:0] prev_w = '0;
   logic [8:0]  prev_r = 9'h100;
   int wcnt = 0, hold = 0, hold_bad = 0, since = 0;
   int rel_cnt = 0, rel_gap = -1, done_gap = -1, done_cnt = 0;

   always @(negedge clk) begin
      if (mon_clr) begin
         wcnt = 0; hold_bad = 0; rel_gap = -1; done_gap = -1; done_cnt = 0;
      end
      if (tst_in !== prev_w) begin
         if (wcnt < 32) wlog[wcnt] = tst_in;
         if (wcnt > 0 && hold != 2) hold_bad++;
         wcnt++;
         hold   = 1;
         since  = 0;
         prev_w = tst_in;
      end else begin
         hold++;
         since++;
      end
      if (rst_ctl !== prev_r) begin
         if (rst_ctl == 9'h101) rel_gap = since;
         rel_cnt = 0;
         prev_r  = rst_ctl;
      end else begin
         rel_cnt++;
      end
      if (done) begin
         done_cnt++;
         done_gap = rel_cnt;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [4:0] f_addr(input int p);
      case (p) 0: return 5'd0; 1: return 5'd6; default: return 5'd26; endcase
   endfunction
   function automatic logic [7:0] f_mask(input int p);
      case (p) 0: return 8'h08; 1: return 8'h3F; default: return 8'hF0; endcase
   endfunction
   function automatic logic [7:0] f_val(input int p);
      case (p) 0: return 8'h08; 1: return 8'h00; default: return 8'h50; endcase
   endfunction
   function automatic logic [7:0] f_new(input int p);
      return (init_arr[f_addr(p)] & ~f_mask(p)) | (f_val(p) & f_mask(p));
   endfunction
   function automatic logic [31:0] f_word(input logic [7:0] d, input logic [4:0] a, input logic we);
      return {18'b0, d, a, we};
   endfunction
   function automatic logic [31:0] f_exp(input int p, input int k);
      case (k)
         0:       return f_word(8'd1, f_addr(p), 1'b0);
         1:       return f_word(f_new(p), f_addr(p), 1'b0);
         2:       return f_word(f_new(p), f_addr(p), 1'b1);
         3:       return f_word(f_new(p), f_addr(p), 1'b0);
         default: return f_word(8'd1, f_addr(p), 1'b0);
      endcase
   endfunction

   task automatic fill(input int mode);
      for (int i = 0; i < 32; i++) begin
         case (mode)
            1:       init_arr[i] = 8'h00;
            2:       init_arr[i] = 8'hFF;
            default: init_arr[i] = 8'($urandom);
         endcase
      end
      junk = 24'($urandom);
      @(negedge clk); #1 load_req = 1'b1;
      @(negedge clk); #1 load_req = 1'b0;
   endtask

   task automatic run(input bit leg, input bit inject);
      logic [8:0] r_before;
      int c;
      string tag;
      r_before = rst_ctl;
      @(negedge clk); #1;
      legacy = leg; start = 1'b1; mon_clr = 1'b1;
      @(negedge clk); #1;
      start = 1'b0; mon_clr = 1'b0;
      if (leg) begin
         chk(done == 1'b1, "R12", "legacy done after start", 32'(done), 32'd1);
         chk(busy == 1'b0, "R12", "legacy busy", 32'(busy), 32'd0);
         repeat (20) @(negedge clk);
         #1;
         chk(wcnt == 0, "R12", "legacy port words", 32'(wcnt), 32'd0);
         chk(rst_ctl == r_before, "R12", "legacy reset ctl", 32'(rst_ctl), 32'(r_before));
         chk(done_cnt == 1, "R12", "legacy done count", 32'(done_cnt), 32'd1);
         return;
      end
      chk(busy == 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
      chk(rst_ctl == 9'h100, "R8", "reset held at start", 32'(rst_ctl), 32'h100);
      c = 0;
      while (!done && c < 3000) begin
         if (!busy) chk(1'b0, "R10", "busy dropped early", 32'(busy), 32'd1);
         if (inject && c == 8)  start = 1'b1;
         if (inject && c == 9)  start = 1'b0;
         @(negedge clk); #1;
         c++;
      end
      if (!done) begin
         chk(1'b0, "R9", "done timeout", 32'(c), 32'd0);
         return;
      end
      chk(busy == 1'b0, "R10", "busy with done", 32'(busy), 32'd0);
      chk(wcnt == 15, "R6", "word count", 32'(wcnt), 32'd15);
      for (int p = 0; p < 3; p++) begin
         for (int k = 0; k < 5; k++) begin
            tag = (k == 0) ? "R3" : (k == 4) ? "R5" : "R4";
            chk(wlog[p*5+k] == f_exp(p, k), tag, $sformatf("word p%0d k%0d", p, k),
                wlog[p*5+k], f_exp(p, k));
            chk((wlog[p*5+k] >> 14) == 0, "R1", "unused bits", wlog[p*5+k] >> 14, 32'd0);
         end
      end
      chk(hold_bad == 0, "R2", "settle holds", 32'(hold_bad), 32'd0);
      chk(rel_gap == 18, "R8", "release gap", 32'(rel_gap), 32'd18);
      chk(done_gap == 16, "R9", "done gap", 32'(done_gap), 32'd16);
      chk(rst_ctl == 9'h101, "R8", "reset released", 32'(rst_ctl), 32'h101);
      chk(mem[0]  == f_new(0), "R6", "reg0",  32'(mem[0]),  32'(f_new(0)));
      chk(mem[6]  == f_new(1), "R7", "reg6",  32'(mem[6]),  32'(f_new(1)));
      chk(mem[26] == f_new(2), "R7", "reg26", 32'(mem[26]), 32'(f_new(2)));
      chk(mem[1]  == init_arr[1], "R6", "untouched reg1", 32'(mem[1]), 32'(init_arr[1]));
      @(negedge clk); #1;
      chk(done == 1'b0, "R9", "done width", 32'(done), 32'd0);
      if (inject) begin
         repeat (40) @(negedge clk);
         #1;
         chk(done_cnt == 1, "R11", "done count after mid-run start", 32'(done_cnt), 32'd1);
         chk(busy == 1'b0, "R11", "busy after mid-run start", 32'(busy), 32'd0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; legacy = 1'b0;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      #1;
      chk(tst_in == 32'd0, "R1", "reset word", tst_in, 32'd0);
      chk(rst_ctl == 9'h100, "R8", "reset ctl", 32'(rst_ctl), 32'h100);
      chk(busy == 1'b0, "R10", "reset busy", 32'(busy), 32'd0);
      chk(done == 1'b0, "R9", "reset done", 32'(done), 32'd0);
      rst_n = 1'b1;
      fill(1); run(1'b0, 1'b0);
      fill(2); run(1'b0, 1'b0);
      fill(0); run(1'b0, 1'b1);
      fill(0); run(1'b1, 1'b0);
      for (int i = 0; i < 4; i++) begin
         fill(0); run(1'b0, 1'b0);
      end
      fill(0); run(1'b1, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule